// File: doc/BRIEF.md
# Memory Bus Interface with Region Decode

This block connects a 16-bit processor core to one shared address space that holds both instructions and data. The core presents a single request at a time: an address, a direction, a byte/word width and write data. The block captures these in an address register and drives that register onto a shared address bus. Instruction fetches, data accesses and peripheral accesses all take this same path, so they never overlap in time.

The registered address is decoded into five regions: special function registers, an 8-bit peripheral window, a 16-bit peripheral window, RAM and flash. While the access is open the block raises one select per region. A memory select ties RAM or flash to the data bus, and a vector flag marks the top 32 bytes of flash. The data bus is modelled as a separate input port and output port with an output enable. The block steers byte lanes, catches misaligned word accesses and accesses to addresses that decode to no region, and flags word accesses into the 8-bit window. The selected region ends each access by returning ready.

Top module: `mbus_region_if`

## Requirements
- R1: After reset `ready_o`, `err_o`, `width_err_o`, `vec_o`, `msel_o`, `mwe_o`, `bus_doe_o` and all region selects are low, and `bus_addr_o` is 0x0000.
- R2: A request seen at a clock edge while the block is idle is captured in the address register. From the next cycle until the cycle in which `ready_o` is high, `bus_addr_o` holds the captured address whatever `addr_i` does, and any request made during that time is ignored.
- R3: A captured address in 0x0000–0x000F raises `sel_sfr_o`, one in 0x0010–0x00FF raises `sel_p8_o`, and one in 0x0100–0x01FF raises `sel_p16_o`. At most one select is high at any time.
- R4: RAM spans 0x0200 to 0x0200+RAM_BYTES-1, which is 0x09FF by default, and raises `sel_ram_o`. Flash spans FLASH_BASE (0xC000 by default) to 0xFFFF and raises `sel_flash_o`. `vec_o` is also high for flash addresses 0xFFE0–0xFFFF.
- R5: `msel_o` is high exactly while `sel_ram_o` or `sel_flash_o` is high.
- R6: `mwe_o` and `bus_doe_o` are high during a write that has a region selected, and are low during every read.
- R7: An address between the end of RAM and FLASH_BASE selects no region. In the first busy cycle `ready_o` and `err_o` are both high, with no select and no write enable, and the block returns to idle.
- R8: A word access at an odd address is refused in the same way as R7, whatever region the address is in.
- R9: A word access into the 8-bit peripheral window raises `width_err_o` together with `sel_p8_o`, and only the low byte moves. A write drives `bus_dout_o` = {0x00, wdata[7:0]}. A read returns `rdata_o` = {0x00, bus_din[7:0]}.
- R10: On a byte write `bus_dout_o` carries the byte in both halves. A byte read returns the byte zero-extended. Outside the 8-bit window the byte is taken from bus_din[7:0] at an even address and from bus_din[15:8] at an odd one. Inside the 8-bit window it is always taken from bus_din[7:0]. A valid word access outside the 8-bit window passes the full 16 bits in each direction.
- R11: During a valid access `ready_o` rises in the same cycle as `bus_ready_i`, and the selects stay high until then. `ready_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Core access request |
| we_i | input | 1 | 1 = write, 0 = read |
| word_i | input | 1 | 1 = word access, 0 = byte access |
| addr_i | input | 16 | Byte address of the access |
| wdata_i | input | 16 | Write data from the core |
| ready_o | output | 1 | Access complete this cycle |
| err_o | output | 1 | Access refused (unmapped or misaligned) |
| rdata_o | output | 16 | Read data, valid with ready_o |
| bus_addr_o | output | 16 | Shared address bus, driven from the address register |
| bus_dout_o | output | 16 | Data bus, outgoing half |
| bus_doe_o | output | 1 | Output enable of the outgoing data |
| bus_din_i | input | 16 | Data bus, incoming half |
| bus_ready_i | input | 1 | Selected region finishes the access |
| sel_sfr_o | output | 1 | Special function register select |
| sel_p8_o | output | 1 | 8-bit peripheral select |
| sel_p16_o | output | 1 | 16-bit peripheral select |
| sel_ram_o | output | 1 | RAM select |
| sel_flash_o | output | 1 | Flash select |
| vec_o | output | 1 | Access falls in the vector area of flash |
| msel_o | output | 1 | Memory connected to the data bus |
| mwe_o | output | 1 | Write enable |
| width_err_o | output | 1 | Word access into the 8-bit window |

## Verification
The bench aims at every window boundary: 0x000F/0x0010, 0x00FF/0x0100, 0x01FF/0x0200, the last RAM byte against the first unmapped byte, and 0xBFFF/0xC000 and 0xFFDF/0xFFE0. An off-by-one compare shows up there as the wrong select, a missing vector flag, or a hole served as memory. While an access waits on a slow region, the bench changes the address inputs and keeps requesting. A design that passed `addr_i` straight through, or accepted a second request, would move `bus_addr_o` or finish early. The bench also checks refused accesses (odd-address words and unmapped holes), byte lanes at odd addresses, and word accesses into the 8-bit window. Each of these catches a design that asserts a select or a write enable on a refused access, or that takes a byte from the wrong half of the bus.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned BYTE_W = DATA_W / 2;

  typedef enum logic [2:0] {
    RG_NONE  = 3'd0,
    RG_SFR   = 3'd1,
    RG_P8    = 3'd2,
    RG_P16   = 3'd3,
    RG_RAM   = 3'd4,
    RG_FLASH = 3'd5
  } region_e;

  localparam int unsigned N_RG = 6;

  localparam logic [ADDR_W-1:0] SFR_LAST = 16'h000F;
  localparam logic [ADDR_W-1:0] P8_LAST  = 16'h00FF;
  localparam logic [ADDR_W-1:0] P16_LAST = 16'h01FF;
  localparam logic [ADDR_W-1:0] RAM_BASE = 16'h0200;
  localparam logic [ADDR_W-1:0] VEC_BASE = 16'hFFE0;

  typedef struct packed {
    logic              we;
    logic              word;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } acc_t;
endpackage

// File: rtl/mbus_decode.sv
module mbus_decode
  import mbus_pkg::*;
#(
  parameter int unsigned       RAM_BYTES  = 2048,
  parameter logic [ADDR_W-1:0] FLASH_BASE = 16'hC000
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              word_i,
  output region_e           region_o,
  output logic              vec_o,
  output logic              misalign_o
);
  localparam int unsigned RAM_LIMIT = 32'(RAM_BASE) + RAM_BYTES;

  logic [31:0] addr_w;
  assign addr_w = 32'(addr_i);

  // first match wins, so RAM takes priority if it were sized into flash
  always_comb begin
    if (addr_i <= SFR_LAST)           region_o = RG_SFR;
    else if (addr_i <= P8_LAST)       region_o = RG_P8;
    else if (addr_i <= P16_LAST)      region_o = RG_P16;
    else if (addr_w < RAM_LIMIT)      region_o = RG_RAM;
    else if (addr_i >= FLASH_BASE)    region_o = RG_FLASH;
    else                              region_o = RG_NONE;
  end

  assign vec_o      = (region_o == RG_FLASH) && (addr_i >= VEC_BASE);
  assign misalign_o = word_i && addr_i[0];
endmodule

// File: rtl/mbus_lane.sv
module mbus_lane
  import mbus_pkg::*;
(
  input  region_e           region_i,
  input  logic              word_i,
  input  logic              addr0_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              width_err_o
);
  logic narrow;
  assign narrow      = (region_i == RG_P8);
  assign width_err_o = narrow && word_i;

  always_comb begin
    if (word_i && !narrow) begin
      dout_o  = wdata_i;
      rdata_o = din_i;
    end else if (word_i) begin
      // 8-bit window: low byte only
      dout_o  = {{BYTE_W{1'b0}}, wdata_i[BYTE_W-1:0]};
      rdata_o = {{BYTE_W{1'b0}}, din_i[BYTE_W-1:0]};
    end else begin
      dout_o  = {wdata_i[BYTE_W-1:0], wdata_i[BYTE_W-1:0]};
      rdata_o = (addr0_i && !narrow) ? {{BYTE_W{1'b0}}, din_i[DATA_W-1:BYTE_W]}
                                     : {{BYTE_W{1'b0}}, din_i[BYTE_W-1:0]};
    end
  end
endmodule

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
  import mbus_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              word_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              done_i,
  output logic              busy_o,
  output acc_t              acc_o
);
  typedef enum logic {ST_IDLE, ST_BUSY} st_e;
  st_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      acc_o <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (req_i) begin
          acc_o <= '{we: we_i, word: word_i, addr: addr_i, wdata: wdata_i};
          st_q  <= ST_BUSY;
        end
        ST_BUSY: if (done_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q == ST_BUSY);
endmodule

// File: rtl/mbus_region_if.sv
module mbus_region_if
  import mbus_pkg::*;
#(
  parameter int unsigned       RAM_BYTES  = 2048,
  parameter logic [ADDR_W-1:0] FLASH_BASE = 16'hC000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              word_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_dout_o,
  output logic              bus_doe_o,
  input  logic [DATA_W-1:0] bus_din_i,
  input  logic              bus_ready_i,
  output logic              sel_sfr_o,
  output logic              sel_p8_o,
  output logic              sel_p16_o,
  output logic              sel_ram_o,
  output logic              sel_flash_o,
  output logic              vec_o,
  output logic              msel_o,
  output logic              mwe_o,
  output logic              width_err_o
);
  logic              busy, done, bad, live;
  acc_t              acc;
  region_e           region;
  logic              dec_vec, misalign, lane_werr;
  logic [DATA_W-1:0] lane_rdata;
  logic [N_RG-1:1]   sel_vec;

  mbus_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .word_i  (word_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .done_i  (done),
    .busy_o  (busy),
    .acc_o   (acc)
  );

  mbus_decode #(.RAM_BYTES(RAM_BYTES), .FLASH_BASE(FLASH_BASE)) u_dec (
    .addr_i     (acc.addr),
    .word_i     (acc.word),
    .region_o   (region),
    .vec_o      (dec_vec),
    .misalign_o (misalign)
  );

  mbus_lane u_lane (
    .region_i    (region),
    .word_i      (acc.word),
    .addr0_i     (acc.addr[0]),
    .wdata_i     (acc.wdata),
    .din_i       (bus_din_i),
    .dout_o      (bus_dout_o),
    .rdata_o     (lane_rdata),
    .width_err_o (lane_werr)
  );

  assign bad  = (region == RG_NONE) || misalign;
  assign live = busy && !bad;
  assign done = busy && (bad || bus_ready_i);

  for (genvar g = 1; g < N_RG; g++) begin : g_sel
    assign sel_vec[g] = live && (region == region_e'(g));
  end

  assign sel_sfr_o   = sel_vec[RG_SFR];
  assign sel_p8_o    = sel_vec[RG_P8];
  assign sel_p16_o   = sel_vec[RG_P16];
  assign sel_ram_o   = sel_vec[RG_RAM];
  assign sel_flash_o = sel_vec[RG_FLASH];

  assign ready_o     = done;
  assign err_o       = busy && bad;
  assign rdata_o     = (live && bus_ready_i) ? lane_rdata : '0;
  assign bus_addr_o  = acc.addr;
  assign mwe_o       = live && acc.we;
  assign bus_doe_o   = mwe_o;
  assign msel_o      = sel_ram_o || sel_flash_o;
  assign vec_o       = live && dec_vec;
  assign width_err_o = live && lane_werr;
endmodule

// File: rtl/mbus_region_if_chk.sv
module mbus_region_if_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ready_o,
  input logic        err_o,
  input logic [15:0] bus_addr_o,
  input logic        bus_doe_o,
  input logic        sel_sfr_o,
  input logic        sel_p8_o,
  input logic        sel_p16_o,
  input logic        sel_ram_o,
  input logic        sel_flash_o,
  input logic        vec_o,
  input logic        msel_o,
  input logic        mwe_o,
  input logic        width_err_o
);
  logic [4:0] sels;
  assign sels = {sel_sfr_o, sel_p8_o, sel_p16_o, sel_ram_o, sel_flash_o};

  assert_one_sel_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sels));

  assert_vec_in_flash_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_o |-> sel_flash_o && (bus_addr_o >= 16'hFFE0));

  assert_no_msel_periph_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_sfr_o || sel_p8_o || sel_p16_o) |-> !msel_o);

  assert_mwe_selected_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mwe_o |-> bus_doe_o && $onehot(sels));

  assert_err_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ready_o && (sels == 5'b0) && !mwe_o);

  assert_width_in_p8_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    width_err_o |-> sel_p8_o);

  assert_addr_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sels != 5'b0) && !ready_o) |=> $stable(bus_addr_o) && $stable(sels));

  assert_single_ready_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
endmodule

bind mbus_region_if mbus_region_if_chk u_chk (.*);

// File: tb/mbus_region_if_bench.sv
`timescale 1ns/1ps
module mbus_region_if_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, word_i = 1'b0;
  logic [15:0] addr_i = '0, wdata_i = '0, bus_din_i = '0;
  logic        bus_ready_i = 1'b0;
  logic        ready_o, err_o, bus_doe_o;
  logic [15:0] rdata_o, bus_addr_o, bus_dout_o;
  logic        sel_sfr_o, sel_p8_o, sel_p16_o, sel_ram_o, sel_flash_o;
  logic        vec_o, msel_o, mwe_o, width_err_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  mbus_region_if u_mbus_region_if (.*);

  function automatic logic [4:0] sels();
    return {sel_sfr_o, sel_p8_o, sel_p16_o, sel_ram_o, sel_flash_o};
  endfunction

  // {sfr,p8,p16,ram,flash}; defaults RAM 0x0200-0x09FF, flash 0xC000-0xFFFF
  function automatic logic [4:0] exp_sel(input logic [15:0] a);
    if (a <= 16'h000F) return 5'b10000;
    if (a <= 16'h00FF) return 5'b01000;
    if (a <= 16'h01FF) return 5'b00100;
    if (a <= 16'h09FF) return 5'b00010;
    if (a >= 16'hC000) return 5'b00001;
    return 5'b00000;
  endfunction

  function automatic logic narrow(input logic [15:0] a);
    return (a >= 16'h0010) && (a <= 16'h00FF);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one access: lat cycles of wait before bus_ready_i
  task automatic access(input logic we, input logic word, input logic [15:0] a,
                        input logic [15:0] wd, input logic [15:0] din, input int lat);
    logic [4:0]  es;
    logic        refused;
    logic [15:0] er, ed;
    es      = exp_sel(a);
    refused = (es == 5'b0) || (word && a[0]);
    if (word && !narrow(a))  begin er = din;                ed = wd; end
    else if (word)           begin er = {8'h00, din[7:0]};  ed = {8'h00, wd[7:0]}; end
    else begin
      ed = {wd[7:0], wd[7:0]};
      er = (a[0] && !narrow(a)) ? {8'h00, din[15:8]} : {8'h00, din[7:0]};
    end
    @(negedge clk_i);
    req_i = 1'b1; we_i = we; word_i = word; addr_i = a; wdata_i = wd;
    @(negedge clk_i);
    addr_i = ~a; bus_din_i = din;
    if (refused) begin
      req_i = 1'b0;
      #1;
      check("R7/R8 ready on refusal", ready_o, 1);
      check("R7/R8 err", err_o, 1);
      check("R7/R8 no select", sels(), 0);
      check("R7/R8 no write enable", {mwe_o, bus_doe_o}, 0);
    end else begin
      for (int i = 0; i < lat; i++) begin
        bus_ready_i = 1'b0;
        #1;
        check("R11 ready waits", ready_o, 0);
        check("R2 address held", bus_addr_o, a);
        check("R3/R4 select while waiting", sels(), es);
        @(negedge clk_i);
      end
      req_i = 1'b0; bus_ready_i = 1'b1;
      #1;
      check("R11 ready with bus ready", ready_o, 1);
      check("R7 no err on valid", err_o, 0);
      check("R2 address at finish", bus_addr_o, a);
      check("R3/R4 select", sels(), es);
      check("R4 vector flag", vec_o, (a >= 16'hFFE0) ? 1 : 0);
      check("R5 memory select", msel_o, (es[1] | es[0]) ? 1 : 0);
      check("R6 write enable", {mwe_o, bus_doe_o}, we ? 2'b11 : 2'b00);
      check("R9 width flag", width_err_o, (word && narrow(a)) ? 1 : 0);
      if (we) check("R9/R10 write lanes", bus_dout_o, ed);
      else    check("R9/R10 read lanes", rdata_o, er);
    end
    @(negedge clk_i);
    bus_ready_i = 1'b0;
    #1;
    check("R11 ready single cycle", ready_o, 0);
    check("R2 idle after finish, no select", sels(), 0);
  endtask

  task automatic t_reset();
    #1;
    check("R1 ready", ready_o, 0);
    check("R1 err", err_o, 0);
    check("R1 selects", sels(), 0);
    check("R1 flags", {vec_o, msel_o, mwe_o, bus_doe_o, width_err_o}, 0);
    check("R1 bus address", bus_addr_o, 16'h0000);
  endtask

  task automatic t_windows();
    access(0, 1, 16'h000E, 0, 16'h1234, 0);  // R3 sfr top
    access(0, 1, 16'h0010, 0, 16'hBEEF, 1);  // R3 p8 bottom (word -> R9)
    access(0, 0, 16'h00FF, 0, 16'hA1B2, 0);  // R3 p8 top
    access(0, 1, 16'h0100, 0, 16'hCAFE, 2);  // R3 p16 bottom
    access(0, 1, 16'h01FE, 0, 16'h0F0F, 0);  // R3 p16 top
    access(0, 1, 16'h0200, 0, 16'h5A5A, 3);  // R4 ram bottom
    access(0, 0, 16'h09FF, 0, 16'h7788, 0);  // R4 ram top
    access(0, 1, 16'hC000, 0, 16'h4321, 1);  // R4 flash bottom
    access(0, 1, 16'hFFDE, 0, 16'h1111, 0);  // R4 below vectors
    access(0, 1, 16'hFFE0, 0, 16'h2222, 0);  // R4 vector bottom
    access(0, 0, 16'hFFFF, 0, 16'h3344, 2);  // R4 vector top
  endtask

  task automatic t_writes();
    access(1, 1, 16'h0400, 16'hDEAD, 0, 1);  // R6 ram word
    access(1, 0, 16'h0105, 16'h00C3, 0, 0);  // R6/R10 p16 byte
    access(1, 1, 16'h0002, 16'h8001, 0, 2);  // R6 sfr word
  endtask

  task automatic t_refused();
    access(0, 1, 16'h0A00, 0, 0, 0);         // R7 first unmapped
    access(1, 0, 16'hBFFF, 16'hFFFF, 0, 0);  // R7 last unmapped, write
    access(1, 1, 16'h0201, 16'h1234, 0, 0);  // R8 odd word in ram
    access(0, 1, 16'hFFE1, 0, 0, 0);         // R8 odd word in vectors
  endtask

  task automatic t_width();
    access(1, 1, 16'h0020, 16'hABCD, 0, 1);  // R9 word write p8
    access(0, 1, 16'h00FE, 0, 16'h9876, 0);  // R9 word read p8
  endtask

  task automatic t_lanes();
    access(0, 0, 16'h0300, 0, 16'h1A2B, 0);  // R10 even byte
    access(0, 0, 16'h0301, 0, 16'h1A2B, 1);  // R10 odd byte
    access(0, 0, 16'h0031, 0, 16'h3C4D, 0);  // R10 odd byte in p8 stays low
    access(1, 0, 16'h0033, 16'h0077, 0, 0);  // R10 byte write p8
  endtask

  initial begin
    #12 rst_ni = 1'b1;
    t_reset();
    t_windows();
    t_writes();
    t_refused();
    t_width();
    t_lanes();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule